// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down-counter that produces a regular time base for a processor. Software reaches it through a simple single-cycle register bus: a select strobe, a write flag, a word address, write data, and an attribute saying the access is unprivileged. Reads return data in the same cycle. An error flag is raised for accesses the block refuses.

Software loads a reload value and sets the enable bit. The counter then counts down to zero and restarts from the reload value, so the period is reload + 1 ticks. A tick is either every core clock cycle or each cycle on which an external reference tick enable is high, chosen by a control bit. Each time the counter moves from 1 to 0, a sticky wrap flag is set. If interrupts are enabled, a one-cycle interrupt request is also raised.

The wrap flag clears when software reads the control register. A write of any value to the current-value register zeroes the counter and clears the flag. A reload value of zero lets the counter stop at zero after its last wrap while the enable bit stays set.

Top module: `tick_timer`

## Requirements
- R1: After reset, control reads 0x0, reload reads 0, current value reads 0, `irq` is low and the counter does not move.
- R2: Word offsets are 0x0 control, 0x4 reload, 0x8 current value and 0xC calibration. Calibration always reads 10000 (0x2710). Any other address reads 0, and writes to it change nothing.
- R3: A control write stores only bits 2:0: bit 0 enables counting, bit 1 enables the interrupt and bit 2 selects the tick source. A control read returns those three bits with the wrap flag at bit 16, and all other bits read 0.
- R4: A reload write keeps bits 23:0 and discards bits 31:24.
- R5: While enabled, each tick loads the reload value if the count is 0, and otherwise decrements the count. With bit 2 = 1, every clock cycle is a tick and `ref_tick` is ignored. With bit 2 = 0, only cycles with `ref_tick` high are ticks.
- R6: On a tick that moves the count from 1 to 0, the wrap flag is set. If bit 1 is set, `irq` is high for exactly the following cycle.
- R7: A privileged control read returns the flag as it stood before the read and then clears it. If a wrap happens on the same edge as the read, the flag stays set.
- R8: A write of any value to the current-value register makes the count 0 and clears the flag. The next tick then loads the reload value.
- R9: With a reload value of 0, after the count reaches 0 it stays at 0 with no further wraps, and the enable bit stays set.
- R10: An access with `bus_user` high returns `bus_err` = 1 and read data 0, changes no register and does not clear the flag. Privileged accesses return `bus_err` = 0.
- R11: With bit 0 clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | Access is unprivileged |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Access refused, valid in the strobe cycle |
| ref_tick | input | 1 | Reference tick enable for the slow source |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
A wrong count or a lost reload shows up in two places. The interrupt pulse moves away from the multiples of reload + 1 ticks within one period, and the current-value register reads a number off by the missed steps at the next read. A flag held in the wrong state is exposed by the next control read, whose bit 16 disagrees with the wrap history; the same-edge case is aimed at directly. Wrongly accepted unprivileged or stray writes appear as changed reload or control readback on the following access.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned FLAG_POS = 16;

    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_LOAD = 4;
    localparam int unsigned OFS_CUR  = 8;
    localparam int unsigned OFS_CAL  = 12;

    // bit 2 = tick source, bit 1 = interrupt enable, bit 0 = run
    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_CAL  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              user_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              err_o,
    output logic              hit_o,
    output reg_sel_e          reg_o,
    output logic              rd_ctrl_o,
    output logic              wr_ctrl_o,
    output logic              wr_load_o,
    output logic              wr_cur_o
);

    logic granted;

    always_comb begin
        reg_o = SEL_CTRL;
        hit_o = 1'b0;
        if (addr_i == ADDR_W'(OFS_CTRL)) begin
            reg_o = SEL_CTRL;
            hit_o = 1'b1;
        end else if (addr_i == ADDR_W'(OFS_LOAD)) begin
            reg_o = SEL_LOAD;
            hit_o = 1'b1;
        end else if (addr_i == ADDR_W'(OFS_CUR)) begin
            reg_o = SEL_CUR;
            hit_o = 1'b1;
        end else if (addr_i == ADDR_W'(OFS_CAL)) begin
            reg_o = SEL_CAL;
            hit_o = 1'b1;
        end
    end

    always_comb begin
        granted   = sel_i && !user_i && hit_o;
        err_o     = sel_i && user_i;
        rd_ctrl_o = granted && !wr_i && (reg_o == SEL_CTRL);
        wr_ctrl_o = granted && wr_i && (reg_o == SEL_CTRL);
        wr_load_o = granted && wr_i && (reg_o == SEL_LOAD);
        wr_cur_o  = granted && wr_i && (reg_o == SEL_CUR);
    end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             src_core_i,
    input  logic             ref_tick_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_wdata_i,
    input  logic             cur_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d     = st_q;
        step     = run_i && (src_core_i || ref_tick_i);
        expire_o = 1'b0;
        if (load_we_i) begin
            st_d.reload = load_wdata_i;
        end
        if (cur_clr_i) begin
            st_d.count = '0;
        end else if (step) begin
            if (st_q.count == '0) begin
                st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
                expire_o   = (st_q.count == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign reload_o = st_q.reload;

    // R11: disabled counter holds its value
    p_hold_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cur_clr_i) |=> (count_o == $past(count_o)));

    // R5: a tick on a nonzero count decrements by one
    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && src_core_i && !cur_clr_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

    // R8: current-value write leaves the counter at zero
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_clr_i |=> (count_o == '0));

    // R9: a zero reload keeps a zero count at zero
    p_zero_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && reload_o == '0 && !load_we_i) |=> (count_o == '0));

endmodule

// File: rtl/tick_ctrl_status.sv
module tick_ctrl_status
    import tick_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_we_i,
    input  ctrl_t ctrl_wdata_i,
    input  logic  ctrl_rd_i,
    input  logic  cur_clr_i,
    input  logic  expire_i,
    output ctrl_t ctrl_o,
    output logic  flag_o,
    output logic  irq_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
        logic  irq;
    } cs_state_t;

    cs_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (ctrl_we_i) begin
            cs_d.ctrl = ctrl_wdata_i;
        end
        if (ctrl_rd_i || cur_clr_i) begin
            cs_d.flag = 1'b0;
        end
        if (expire_i) begin
            cs_d.flag = 1'b1;
        end
        cs_d.irq = expire_i && cs_q.ctrl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ctrl_o = cs_q.ctrl;
    assign flag_o = cs_q.flag;
    assign irq_o  = cs_q.irq;

    // R6: interrupt lasts a single cycle
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R6: an interrupt always comes with the wrap flag
    p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R7: a read without a concurrent wrap clears the flag
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_i && !expire_i) |=> !flag_o);

    // R7: a wrap is never lost to a concurrent read
    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_user,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              ref_tick,
    output logic              irq
);

    reg_sel_e         reg_sel;
    logic             hit;
    logic             rd_ctrl, wr_ctrl, wr_load, wr_cur;
    logic [CNT_W-1:0] count, reload;
    logic             expire, flag;
    ctrl_t            ctrl;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata;

    tick_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .user_i    (bus_user),
        .addr_i    (bus_addr),
        .err_o     (bus_err),
        .hit_o     (hit),
        .reg_o     (reg_sel),
        .rd_ctrl_o (rd_ctrl),
        .wr_ctrl_o (wr_ctrl),
        .wr_load_o (wr_load),
        .wr_cur_o  (wr_cur)
    );

    tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (ctrl.run),
        .src_core_i   (ctrl.src_core),
        .ref_tick_i   (ref_tick),
        .load_we_i    (wr_load),
        .load_wdata_i (bus_wdata[CNT_W-1:0]),
        .cur_clr_i    (wr_cur),
        .count_o      (count),
        .reload_o     (reload),
        .expire_o     (expire)
    );

    tick_ctrl_status u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we_i    (wr_ctrl),
        .ctrl_wdata_i (ctrl_t'(bus_wdata[2:0])),
        .ctrl_rd_i    (rd_ctrl),
        .cur_clr_i    (wr_cur),
        .expire_i     (expire),
        .ctrl_o       (ctrl),
        .flag_o       (flag),
        .irq_o        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && !bus_user && hit) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    bus_rdata[2:0]      = ctrl;
                    bus_rdata[FLAG_POS] = flag;
                end
                SEL_LOAD: bus_rdata[CNT_W-1:0] = reload;
                SEL_CUR:  bus_rdata[CNT_W-1:0] = count;
                SEL_CAL:  bus_rdata = WORD_W'(CAL_VALUE);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R10: refused accesses leave control and reload untouched
    p_user_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_user) |=> ($stable(reload) && $stable(ctrl)));

    // R10: refused reads return zero data
    p_user_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_LOAD = 8'h04;
    localparam logic [7:0] A_CUR  = 8'h08;
    localparam logic [7:0] A_CAL  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_user = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ref_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    tick_timer u_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_user  (bus_user),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ref_tick  (ref_tick),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic usr, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_user = usr; bus_addr = a; bus_wdata = d;
        #1 err = bus_err;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0; bus_user = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic usr, output logic [31:0] d, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_user = usr; bus_addr = a;
        #1 d = bus_rdata; err = bus_err;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_user = 1'b0;
    endtask

    // Period check: expects irq exactly on ticks multiple of (n+1)*div
    task automatic sweep(input int n, input logic core, input int ref_div, input int eff_div);
        logic e;
        int   period;
        period = (n + 1) * eff_div;
        wr(A_LOAD, 32'(n), 1'b0, e);
        wr(A_CUR, 32'hDEAD, 1'b0, e);
        wr(A_CTRL, {29'd0, core, 2'b11}, 1'b0, e);
        for (int cyc = 1; cyc <= 3 * period; cyc++) begin
            @(negedge clk);
            ref_tick = ((cyc % ref_div) == 0);
            @(posedge clk);
            #1 check($sformatf("R5/R6 irq n=%0d core=%0d cyc=%0d", n, core, cyc),
                     32'(irq), 32'((cyc % period) == 0));
        end
        @(negedge clk);
        ref_tick = 1'b0;
        wr(A_CTRL, 32'd0, 1'b0, e);
        wr(A_CUR, 32'd0, 1'b0, e);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 map and calibration
        rd(A_CTRL, 1'b0, d, e); check("R1 ctrl", d, 32'h0);
        rd(A_LOAD, 1'b0, d, e); check("R1 reload", d, 32'h0);
        rd(A_CUR, 1'b0, d, e);  check("R1 current", d, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(A_CAL, 1'b0, d, e);  check("R2 calibration", d, 32'd10000);
        check("R10 privileged err", 32'(e), 32'h0);

        // R4 reload width, R3 control bits
        wr(A_LOAD, 32'hFFAB_CDEF, 1'b0, e);
        rd(A_LOAD, 1'b0, d, e); check("R4 reload trim", d, 32'h00AB_CDEF);
        wr(A_CTRL, 32'hFFFF_FFFA, 1'b0, e);
        rd(A_CTRL, 1'b0, d, e); check("R3 ctrl bits", d, 32'h0000_0002);
        rd(A_CUR, 1'b0, d, e);  check("R1 not counting", d, 32'h0);
        wr(A_CTRL, 32'h0, 1'b0, e);

        // R2 stray offsets
        wr(8'h10, 32'hFFFF_FFFF, 1'b0, e);
        wr(8'h06, 32'hFFFF_FFFF, 1'b0, e);
        rd(8'h10, 1'b0, d, e); check("R2 stray read", d, 32'h0);
        rd(8'h02, 1'b0, d, e); check("R2 unaligned read", d, 32'h0);
        rd(A_LOAD, 1'b0, d, e); check("R2 reload kept", d, 32'h00AB_CDEF);
        rd(A_CTRL, 1'b0, d, e); check("R2 ctrl kept", d, 32'h0);

        // R10 unprivileged accesses
        wr(A_LOAD, 32'h55, 1'b0, e);
        wr(A_LOAD, 32'h77, 1'b1, e); check("R10 write err", 32'(e), 32'h1);
        wr(A_CTRL, 32'h7, 1'b1, e);
        rd(A_LOAD, 1'b0, d, e); check("R10 reload kept", d, 32'h55);
        rd(A_CTRL, 1'b0, d, e); check("R10 ctrl kept", d, 32'h0);
        rd(A_CAL, 1'b1, d, e);
        check("R10 read err", 32'(e), 32'h1);
        check("R10 read data", d, 32'h0);

        // R5/R6 period sweep: core clock, reference ticks, ignored ref on core
        for (int n = 1; n <= 5; n++) begin
            sweep(n, 1'b1, 1, 1);
            sweep(n, 1'b0, 3, 3);
            sweep(n, 1'b1, 3, 1);
            sweep(n, 1'b0, 1, 1);
        end

        // R7 same-edge wrap and read: reload 4, wrap on edge 5
        wr(A_LOAD, 32'd4, 1'b0, e);
        wr(A_CUR, 32'd0, 1'b0, e);
        wr(A_CTRL, 32'h5, 1'b0, e);
        repeat (4) @(posedge clk);
        rd(A_CTRL, 1'b0, d, e); check("R7 read before wrap", d, 32'h5);
        rd(A_CTRL, 1'b0, d, e); check("R7 set wins", d, 32'h0001_0005);
        rd(A_CTRL, 1'b0, d, e); check("R7 cleared by read", d, 32'h5);

        // R8 current write: zero, flag clear, then reload
        repeat (6) @(posedge clk);
        wr(A_CUR, 32'h1234_5678, 1'b0, e);
        rd(A_CUR, 1'b0, d, e);  check("R8 zeroed", d, 32'h0);
        rd(A_CUR, 1'b0, d, e);  check("R8 reload next tick", d, 32'd4);
        wr(A_CTRL, 32'h0, 1'b0, e);
        wr(A_CUR, 32'h0, 1'b0, e);
        rd(A_CTRL, 1'b0, d, e); check("R8 flag cleared", d, 32'h0);

        // R9 zero reload after a final wrap; R10 user read keeps flag
        wr(A_LOAD, 32'd3, 1'b0, e);
        wr(A_CUR, 32'd0, 1'b0, e);
        wr(A_CTRL, 32'h5, 1'b0, e);
        wr(A_LOAD, 32'd0, 1'b0, e);
        repeat (20) @(posedge clk);
        rd(A_CTRL, 1'b1, d, e); check("R10 user ctrl read", d, 32'h0);
        rd(A_CTRL, 1'b0, d, e); check("R9 wrapped, still enabled", d, 32'h0001_0005);
        rd(A_CUR, 1'b0, d, e);  check("R9 held at zero", d, 32'h0);
        repeat (10) @(posedge clk);
        rd(A_CTRL, 1'b0, d, e); check("R9 no further wrap", d, 32'h5);
        check("R9 no irq", 32'(irq), 32'h0);
        wr(A_CTRL, 32'h0, 1'b0, e);

        // R11 disable freezes the count
        wr(A_LOAD, 32'd100, 1'b0, e);
        wr(A_CUR, 32'd0, 1'b0, e);
        wr(A_CTRL, 32'h5, 1'b0, e);
        repeat (10) @(posedge clk);
        wr(A_CTRL, 32'h0, 1'b0, e);
        rd(A_CUR, 1'b0, d, e); check("R11 count at disable", d, 32'd90);
        repeat (10) @(posedge clk);
        rd(A_CUR, 1'b0, d, e); check("R11 count held", d, 32'd90);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule